// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor Core

This block is a small processor built around a single accumulator. It runs every instruction as a fixed series of register transfers, one per clock, through an address register, a data register, a program counter and an instruction register. Instructions and data share one word-wide memory port. The port has an address, write data, a write enable and read data that arrives one clock after the address.

The core starts fetching at address zero when reset is released, provided the run input is high. It keeps going until it executes a stop instruction, or until it finds the run input low at the start of a fetch. In either case it parks in a halted state that only reset can leave. The accumulator is brought out so that a program's result can be observed. The halted output reports when execution has ended.

Top module: `acc_core`

## Requirements
- R1: A fetch puts the program counter on the memory address, waits one clock for the read, loads the data register, loads the instruction register, and then adds one to the program counter. The fetch takes five clocks and fetches proceed from consecutive addresses.
- R2: If run is low when a fetch is about to begin, the core enters the halted state after that clock and performs no further memory access.
- R3: Opcode 1 (load) copies the memory word at the address field into the accumulator.
- R4: Opcode 2 (store) writes the accumulator value to the memory word at the address field, with mem_we high for one clock, and leaves the accumulator unchanged.
- R5: Opcode 5 adds and opcode 6 subtracts the memory word at the address field to or from the accumulator, wrapping modulo 2^16.
- R6: Opcode 7 multiplies the accumulator by the memory word and keeps the low 16 bits of the product.
- R7: Opcode 15 continues execution at the address field.
- R8: Opcode 16 continues execution at the address field only when the accumulator, read as signed, is strictly greater than zero. When the accumulator is zero or negative, execution continues at the next word.
- R9: Opcode 21 stops the core. halted then stays high, mem_we stays low and the accumulator keeps its value.
- R10: Every other opcode value (for example 0, 3 or 31) has no effect, and the next instruction is fetched.
- R11: An instruction word carries its opcode in bits [15:11] and its address in bits [10:0]. Data words are 16-bit two's complement.
- R12: The clocks per instruction, counting the fetch, are: 9 for load, add, subtract and multiply, 8 for store, 6 for either jump, and 5 for stop and for an undefined opcode.
- R13: While reset is held, the accumulator reads zero, halted and mem_we are low, and mem_addr is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Permits the next fetch when high |
| mem_addr | output | ADDR_W (11) | Memory word address |
| mem_wdata | output | DATA_W (16) | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W (16) | Read data, valid one clock after the address |
| acc | output | DATA_W (16) | Accumulator value |
| halted | output | 1 | Execution has ended |

## Verification
A straight-line program applies load, add with a negative operand, multiply, subtract and store. Its result separates the arithmetic operations from one another and from a plain copy. A countdown loop checks the conditional jump: it must be taken for positive values and not taken at zero, and every store on the way must match. A third program covers the remaining cases: a wrap into the sign bit that blocks a jump on a negative value, an unconditional jump over dead code, undefined opcodes, and a multiply that overflows. The exact clock count to halt in each program catches any missing or extra micro-step, and a run-low start shows that the core halts before fetching.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // Opcode values; the numbering is sparse on purpose.
  localparam int unsigned OPC_LOAD  = 1;
  localparam int unsigned OPC_STORE = 2;
  localparam int unsigned OPC_ADD   = 5;
  localparam int unsigned OPC_SUB   = 6;
  localparam int unsigned OPC_MUL   = 7;
  localparam int unsigned OPC_JMP   = 15;
  localparam int unsigned OPC_JPOS  = 16;
  localparam int unsigned OPC_STOP  = 21;

  typedef enum logic [3:0] {
    US_F_ADDR,   // AR <- PC (or halt when not running)
    US_F_WAIT,   // memory read latency
    US_F_DATA,   // DR <- memory
    US_F_OPC,    // IR <- opcode field of DR
    US_F_NEXT,   // PC <- PC + 1, dispatch
    US_X_ADDR,   // AR <- address field of DR
    US_X_WAIT,   // memory read latency
    US_X_DATA,   // DR <- memory
    US_X_ALU,    // ACC <- f(ACC, DR)
    US_S_DATA,   // DR <- ACC
    US_S_WRITE,  // memory[AR] <- DR
    US_JMP,      // PC <- address field
    US_JPOS,     // PC <- address field if ACC > 0
    US_HALT      // parked
  } ustep_e;

  typedef enum logic [2:0] {
    CL_MEMRD, CL_STORE, CL_JMP, CL_JPOS, CL_STOP, CL_NOP
  } op_class_e;

  typedef struct packed {
    logic ar_from_pc;
    logic ar_from_dr;
    logic dr_from_mem;
    logic dr_from_acc;
    logic ir_load;
    logic pc_inc;
    logic pc_jump;
    logic acc_load;
    logic mem_we;
  } ctl_t;

  function automatic op_class_e classify(input int unsigned code);
    case (code)
      OPC_LOAD, OPC_ADD, OPC_SUB, OPC_MUL: return CL_MEMRD;
      OPC_STORE:                           return CL_STORE;
      OPC_JMP:                             return CL_JMP;
      OPC_JPOS:                            return CL_JPOS;
      OPC_STOP:                            return CL_STOP;
      default:                             return CL_NOP;
    endcase
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 5
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              acc_pos
);
  import acc_pkg::*;

  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [DATA_W-1:0] mul_low(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic [PROD_W-1:0] full;
    full = PROD_W'(a) * PROD_W'(b);
    return full[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] apply(input int unsigned code,
                                              input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    case (code)
      OPC_LOAD: return b;
      OPC_ADD:  return a + b;
      OPC_SUB:  return a - b;
      OPC_MUL:  return mul_low(a, b);
      default:  return a;
    endcase
  endfunction

  function automatic logic is_positive(input logic [DATA_W-1:0] v);
    return !v[DATA_W-1] && (|v);
  endfunction

  assign result  = apply(int'(opc), acc_in, operand);
  assign acc_pos = is_positive(acc_in);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl #(
  parameter int OPC_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [OPC_W-1:0]   opc,
  input  logic               acc_pos,
  output acc_pkg::ustep_e    step,
  output acc_pkg::ctl_t      ctl
);
  import acc_pkg::*;

  ustep_e    step_q, step_d;
  op_class_e cls;

  assign cls  = classify(int'(opc));
  assign step = step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= US_F_ADDR;
    else     step_q <= step_d;
  end

  always_comb begin
    ctl    = '0;
    step_d = step_q;
    case (step_q)
      US_F_ADDR: begin
        if (run) begin
          ctl.ar_from_pc = 1'b1;
          step_d         = US_F_WAIT;
        end else begin
          step_d = US_HALT;
        end
      end
      US_F_WAIT: step_d = US_F_DATA;
      US_F_DATA: begin
        ctl.dr_from_mem = 1'b1;
        step_d          = US_F_OPC;
      end
      US_F_OPC: begin
        ctl.ir_load = 1'b1;
        step_d      = US_F_NEXT;
      end
      US_F_NEXT: begin
        ctl.pc_inc = 1'b1;
        case (cls)
          CL_MEMRD, CL_STORE: step_d = US_X_ADDR;
          CL_JMP:             step_d = US_JMP;
          CL_JPOS:            step_d = US_JPOS;
          CL_STOP:            step_d = US_HALT;
          default:            step_d = US_F_ADDR;
        endcase
      end
      US_X_ADDR: begin
        ctl.ar_from_dr = 1'b1;
        step_d         = (cls == CL_STORE) ? US_S_DATA : US_X_WAIT;
      end
      US_X_WAIT: step_d = US_X_DATA;
      US_X_DATA: begin
        ctl.dr_from_mem = 1'b1;
        step_d          = US_X_ALU;
      end
      US_X_ALU: begin
        ctl.acc_load = 1'b1;
        step_d       = US_F_ADDR;
      end
      US_S_DATA: begin
        ctl.dr_from_acc = 1'b1;
        step_d          = US_S_WRITE;
      end
      US_S_WRITE: begin
        ctl.mem_we = 1'b1;
        step_d     = US_F_ADDR;
      end
      US_JMP: begin
        ctl.pc_jump = 1'b1;
        step_d      = US_F_ADDR;
      end
      US_JPOS: begin
        ctl.pc_jump = acc_pos;
        step_d      = US_F_ADDR;
      end
      US_HALT: step_d = US_HALT;
      default: step_d = US_HALT;
    endcase
  end

  // Once parked, the sequencer never leaves (R9).
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (step_q == US_HALT) |=> (step_q == US_HALT));

  // A fetch attempted with run low ends execution (R2).
  assert_idle_halts_R2: assert property (@(posedge clk) disable iff (rst)
    (step_q == US_F_ADDR && !run) |=> (step_q == US_HALT));

  // At most one source drives each register in a cycle (R1).
  assert_single_src_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.ar_from_pc, ctl.ar_from_dr}) && $onehot0({ctl.dr_from_mem, ctl.dr_from_acc})
    && $onehot0({ctl.pc_inc, ctl.pc_jump}));

endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic              halted
);
  import acc_pkg::*;

  localparam int OPC_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [DATA_W-1:0] dr_q, acc_q;
  logic [OPC_W-1:0]  ir_q;
  logic [DATA_W-1:0] alu_result;
  logic              acc_pos;
  ustep_e            step;
  ctl_t              ctl;

  // Named field views of the data register
  logic [ADDR_W-1:0] dr_addr_field;
  logic [OPC_W-1:0]  dr_opc_field;
  assign dr_addr_field = dr_q[ADDR_W-1:0];
  assign dr_opc_field  = dr_q[DATA_W-1 -: OPC_W];

  // Named events for the checks below
  logic ev_jpos_taken;
  assign ev_jpos_taken = (step == US_JPOS) && ctl.pc_jump;

  acc_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .opc     (ir_q),
    .acc_pos (acc_pos),
    .step    (step),
    .ctl     (ctl)
  );

  acc_alu #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_alu (
    .opc     (ir_q),
    .acc_in  (acc_q),
    .operand (dr_q),
    .result  (alu_result),
    .acc_pos (acc_pos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q  <= '0;
      pc_q  <= '0;
      dr_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (ctl.ar_from_pc)       ar_q <= pc_q;
      else if (ctl.ar_from_dr)  ar_q <= dr_addr_field;

      if (ctl.dr_from_mem)      dr_q <= mem_rdata;
      else if (ctl.dr_from_acc) dr_q <= acc_q;

      if (ctl.ir_load)          ir_q <= dr_opc_field;

      if (ctl.pc_inc)           pc_q <= pc_q + 1'b1;
      else if (ctl.pc_jump)     pc_q <= dr_addr_field;

      if (ctl.acc_load)         acc_q <= alu_result;
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = dr_q;
  assign mem_we    = ctl.mem_we;
  assign acc       = acc_q;
  assign halted    = (step == US_HALT);

  // The written word is the accumulator captured one step earlier (R4).
  assert_store_value_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == $past(acc_q)));

  // A store leaves the accumulator alone (R4).
  assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(acc_q));

  // A fetch addresses memory with the program counter (R1).
  assert_fetch_addr_R1: assert property (@(posedge clk) disable iff (rst)
    ctl.ar_from_pc |=> (mem_addr == $past(pc_q)));

  // A taken conditional jump needs a strictly positive accumulator (R8).
  assert_jpos_sign_R8: assert property (@(posedge clk) disable iff (rst)
    ev_jpos_taken |-> ($signed(acc_q) > 0));

  // Halted: no writes and a frozen accumulator (R9).
  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
  assert_halt_acc_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(acc_q));

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int MEMSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] acc;
  logic          halted;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem     [MEMSZ];
  logic [DW-1:0] mem_ref [MEMSZ];

  int exp_addr_q[$];
  int exp_data_q[$];

  always #5 clk = ~clk;

  acc_core #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .run(run),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .acc(acc), .halted(halted)
  );

  // Synchronous memory, one clock of read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares every memory write with the scoreboard (R4)
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R4/R9 unexpected write", int'(mem_addr), -1);
      end else begin
        int ea, ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        check(int'(mem_addr) == ea, "R4 store address", int'(mem_addr), ea);
        check(int'(mem_wdata) == ed, "R4 store data", int'(mem_wdata), ed);
      end
    end
  end

  // R11: opcode in [15:11], address in [10:0]
  function automatic logic [DW-1:0] ins(input int op, input int a);
    return {op[4:0], a[AW-1:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < MEMSZ; i++) mem[i] = '0;
  endtask

  // Reference interpreter written from the requirements
  task automatic model(input bit run_val, output int cyc, output int acc_end);
    int pc, a, op, w;
    logic [DW-1:0] ac;
    logic [2*DW-1:0] prod;
    bit done;
    for (int i = 0; i < MEMSZ; i++) mem_ref[i] = mem[i];
    pc = 0; ac = '0; cyc = 0; done = 0;
    if (!run_val) begin
      cyc = 1;
      done = 1;
    end
    for (int n = 0; n < 4000 && !done; n++) begin
      w  = int'(mem_ref[pc]);
      op = (w >> AW) & 31;
      a  = w & (MEMSZ - 1);
      pc = (pc + 1) % MEMSZ;
      cyc += 5;
      case (op)
        1:  begin ac = mem_ref[a]; cyc += 4; end
        2:  begin mem_ref[a] = ac; exp_addr_q.push_back(a);
                  exp_data_q.push_back(int'(ac)); cyc += 3; end
        5:  begin ac = ac + mem_ref[a]; cyc += 4; end
        6:  begin ac = ac - mem_ref[a]; cyc += 4; end
        7:  begin prod = {{DW{1'b0}}, ac} * {{DW{1'b0}}, mem_ref[a]};
                  ac = prod[DW-1:0]; cyc += 4; end
        15: begin pc = a; cyc += 1; end
        16: begin if (!ac[DW-1] && ac != 0) pc = a; cyc += 1; end
        21: done = 1;
        default: ;
      endcase
    end
    acc_end = int'(ac);
  endtask

  task automatic run_prog(input bit run_val, input string req);
    int exp_cyc, exp_acc, n;
    logic [DW-1:0] held;
    exp_addr_q.delete();
    exp_data_q.delete();
    model(run_val, exp_cyc, exp_acc);
    rst = 1'b1;
    run = run_val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(acc == 0 && !halted && !mem_we && mem_addr == 0, "R13 reset state",
          int'({halted, mem_we, acc}), 0);
    rst = 1'b0;
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (halted) break;
    end
    check(n == exp_cyc, {req, " R1 R12 clocks to halt"}, n, exp_cyc);
    check(int'(acc) == exp_acc, {req, " final accumulator"}, int'(acc), exp_acc);
    check(exp_addr_q.size() == 0, {req, " R4 all stores seen"}, exp_addr_q.size(), 0);
    held = acc;
    repeat (20) @(negedge clk);
    check(halted && acc == held, "R9 halt is sticky and acc frozen", int'(acc), int'(held));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Program A: load, add negative, multiply, subtract, store (R3 R5 R6)
    clear_mem();
    mem[0] = ins(1, 100);
    mem[1] = ins(5, 101);
    mem[2] = ins(7, 102);
    mem[3] = ins(6, 100);
    mem[4] = ins(2, 200);
    mem[5] = ins(21, 0);
    mem[100] = 16'd7;
    mem[101] = 16'hFFFD;
    mem[102] = 16'd5;
    run_prog(1'b1, "R3 R5 R6");

    // Program B: countdown loop, jump taken while positive, not at zero (R8)
    clear_mem();
    mem[0] = ins(1, 100);
    mem[1] = ins(2, 200);
    mem[2] = ins(6, 101);
    mem[3] = ins(16, 1);
    mem[4] = ins(2, 201);
    mem[5] = ins(21, 0);
    mem[100] = 16'd3;
    mem[101] = 16'd1;
    run_prog(1'b1, "R8 loop");

    // Program C: wrap to negative, jump over dead code, undefined opcodes,
    // multiply overflow, taken conditional jump (R5 R6 R7 R8 R10)
    clear_mem();
    mem[0]  = ins(1, 100);
    mem[1]  = ins(5, 101);
    mem[2]  = ins(16, 6);
    mem[3]  = ins(2, 200);
    mem[4]  = ins(15, 8);
    mem[5]  = ins(2, 201);
    mem[6]  = ins(2, 202);
    mem[7]  = ins(21, 0);
    mem[8]  = ins(3, 100);
    mem[9]  = ins(31, 101);
    mem[10] = ins(1, 102);
    mem[11] = ins(7, 102);
    mem[12] = ins(16, 6);
    mem[100] = 16'h7FFF;
    mem[101] = 16'd1;
    mem[102] = 16'd300;
    run_prog(1'b1, "R5 R6 R7 R8 R10");

    // Program D: run low before the first fetch; the store must never occur (R2)
    clear_mem();
    mem[0] = ins(2, 50);
    mem[1] = ins(21, 0);
    run_prog(1'b0, "R2");
    check(mem[50] == 0, "R2 no memory access", int'(mem[50]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule